// File: doc/BRIEF.md
# Early Way Determination Lookup Array

This block holds a shadow copy of a two-way L1 data cache's tag array and of its address translation table. When memory instructions enter the load/store queue, their virtual addresses are presented on several lookup ports in the same cycle. Each lookup translates the page number through the shadow translation table. The set index is taken from the untranslated address bits, and the resulting physical tag is compared against both ways of that set. The answer comes back one cycle later. It says whether the destination way is already known and, if so, which way it is. The cache access stage can then enable a single data way instead of all of them.

The cache's replacement logic drives the update ports in the same cycle it writes the main tags and translation table, so the two copies never diverge. Several update writes may land per cycle. A lookup that reads an entry being rewritten in that same cycle is not allowed to use it and counts as a miss. Results say which kind of miss happened, so the cache access stage can tell a missing translation from a missing tag.

The virtual address is split as follows: page number above `PAGE_W`, set index at `[LINE_W +: SET_W]`, and the line offset below it. The index lies inside the page offset (`LINE_W + SET_W <= PAGE_W`), so the set can be selected before translation.

Top module: `eta_lookup_array`

## Requirements
- R1: While reset is held and until the first lookup after reset, `rs_valid` is 0. Reset invalidates every tag and translation entry, so a lookup issued after reset reports a translation miss.
- R2: A lookup on port i in cycle t produces `rs_valid[i]=1` in cycle t+1, with `rs_id[i]` equal to the request's identifier. An idle port gives `rs_valid[i]=0` one cycle later.
- R3: A hit requires a valid translation entry whose page number matches and a valid way in the indexed set whose stored tag equals `paddr[PA_W-1 -: TAG_W]`. It reports `rs_hit=1`, `rs_miss=2'b00`, `rs_way` set to the matching way, and `rs_paddr = {ppn, vaddr[PAGE_W-1:0]}`.
- R4: When the translation hits but no usable way matches, the result is an early tag miss: `rs_hit=0`, `rs_miss=2'b01`, `rs_way=0`, and `rs_paddr` still holds the translated address.
- R5: When no usable translation entry matches, the result is an early translation miss: `rs_hit=0`, `rs_miss=2'b10`, `rs_way=0`, `rs_paddr=0`.
- R6: An update write (tag to a set and way, or page pair to a translation slot) takes effect for lookups from the next cycle on. A write with its valid input at 0 removes the entry.
- R7: A tag update to the same set and way that a lookup reads in the same cycle blocks that way for that lookup. If no other way matches, the result is a tag miss. Updates to another way or another set leave the lookup unaffected.
- R8: A translation update to a slot in the same cycle blocks that slot for every lookup. A lookup that would have matched only that slot reports a translation miss. Updates to other slots leave it unaffected.
- R9: All lookup ports and all update ports work in the same cycle, each independent of the others. When two update ports write the same entry in one cycle, the higher-numbered port's contents are kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| lk_valid | input | NUM_LK | Lookup request per port |
| lk_id | input | NUM_LK x ID_W | Request identifier per port |
| lk_vaddr | input | NUM_LK x VA_W | Virtual address per port |
| tu_en | input | NUM_UP | Tag update enable per port |
| tu_set | input | NUM_UP x SET_W | Tag update set |
| tu_way | input | NUM_UP x WAY_W | Tag update way |
| tu_tag | input | NUM_UP x TAG_W | Physical tag written |
| tu_valid | input | NUM_UP | Valid bit written with the tag |
| xu_en | input | NUM_UP | Translation update enable per port |
| xu_slot | input | NUM_UP x SLOT_W | Translation slot written |
| xu_vpn | input | NUM_UP x VPN_W | Virtual page number written |
| xu_ppn | input | NUM_UP x PPN_W | Physical page number written |
| xu_valid | input | NUM_UP | Valid bit written with the pair |
| rs_valid | output | NUM_LK | Result valid per port |
| rs_id | output | NUM_LK x ID_W | Echoed identifier |
| rs_hit | output | NUM_LK | Early destination way found |
| rs_way | output | NUM_LK x WAY_W | Early destination way |
| rs_paddr | output | NUM_LK x PA_W | Translated physical address |
| rs_miss | output | NUM_LK x 2 | Miss kind: 00 none, 01 tag, 10 translation |

## Verification
The bench sets up same-cycle collisions. In one, a tag rewrite lands on the set and way a lookup reads, while another port rewrites the neighbouring way. In another, a translation slot is rewritten while a lookup depends on it. A design that forwarded the new contents, or that blocked a whole set instead of a single way, would report a hit in the first case or a miss in the second. Two update ports writing the same entry in one cycle expose a reversed port priority. An invalidating write exposes a design that writes the tag but leaves the valid bit set. A long mixed phase of lookups and updates over a small address pool checks that the miss kinds, the way and the translated address stay distinct and correct.

// File: rtl/eta_pkg.sv
package eta_pkg;
  typedef enum logic [1:0] {
    MISS_NONE = 2'b00,
    MISS_TAG  = 2'b01,
    MISS_XLT  = 2'b10
  } miss_kind_e;
endpackage

// File: rtl/eta_xlt_shadow.sv
module eta_xlt_shadow #(
  parameter int NUM_RD  = 2,
  parameter int NUM_WR  = 2,
  parameter int ENTRIES = 4,
  parameter int SLOT_W  = 2,
  parameter int VPN_W   = 20,
  parameter int PPN_W   = 20
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic [NUM_RD-1:0][VPN_W-1:0]     rd_vpn,
  output logic [NUM_RD-1:0]                rd_hit,
  output logic [NUM_RD-1:0][PPN_W-1:0]     rd_ppn,
  input  logic [NUM_WR-1:0]                wr_en,
  input  logic [NUM_WR-1:0][SLOT_W-1:0]    wr_slot,
  input  logic [NUM_WR-1:0][VPN_W-1:0]     wr_vpn,
  input  logic [NUM_WR-1:0][PPN_W-1:0]     wr_ppn,
  input  logic [NUM_WR-1:0]                wr_valid
);
  logic [ENTRIES-1:0]             v_q, v_d, ent_we, blk;
  logic [VPN_W-1:0]               vpn_q [ENTRIES];
  logic [VPN_W-1:0]               vpn_d [ENTRIES];
  logic [PPN_W-1:0]               ppn_q [ENTRIES];
  logic [PPN_W-1:0]               ppn_d [ENTRIES];

  // next state: later write ports override earlier ones
  always_comb begin
    v_d    = v_q;
    ent_we = '0;
    blk    = '0;
    for (int e = 0; e < ENTRIES; e++) begin
      vpn_d[e] = vpn_q[e];
      ppn_d[e] = ppn_q[e];
      for (int j = 0; j < NUM_WR; j++) begin
        if (wr_en[j] && (wr_slot[j] == SLOT_W'(e))) begin
          blk[e]    = 1'b1;
          ent_we[e] = 1'b1;
          v_d[e]    = wr_valid[j];
          vpn_d[e]  = wr_vpn[j];
          ppn_d[e]  = wr_ppn[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENTRIES; e++) begin
      if (ent_we[e]) begin
        vpn_q[e] <= vpn_d[e];
        ppn_q[e] <= ppn_d[e];
      end
    end
  end

  // search: lowest unblocked valid match wins
  generate
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      always_comb begin
        rd_hit[r] = 1'b0;
        rd_ppn[r] = '0;
        for (int e = ENTRIES - 1; e >= 0; e--) begin
          if (v_q[e] && !blk[e] && (vpn_q[e] == rd_vpn[r])) begin
            rd_hit[r] = 1'b1;
            rd_ppn[r] = ppn_q[e];
          end
        end
      end
    end
  endgenerate

  AST_XLT_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[NUM_WR-1] |=> (v_q[$past(wr_slot[NUM_WR-1])] == $past(wr_valid[NUM_WR-1]))); // R6
endmodule

// File: rtl/eta_tag_shadow.sv
module eta_tag_shadow #(
  parameter int NUM_RD = 2,
  parameter int NUM_WR = 2,
  parameter int SETS   = 16,
  parameter int WAYS   = 2,
  parameter int SET_W  = 4,
  parameter int WAY_W  = 1,
  parameter int TAG_W  = 24
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_RD-1:0][SET_W-1:0]    rd_set,
  input  logic [NUM_RD-1:0][TAG_W-1:0]    rd_tag,
  output logic [NUM_RD-1:0]               rd_hit,
  output logic [NUM_RD-1:0][WAY_W-1:0]    rd_way,
  input  logic [NUM_WR-1:0]               wr_en,
  input  logic [NUM_WR-1:0][SET_W-1:0]    wr_set,
  input  logic [NUM_WR-1:0][WAY_W-1:0]    wr_way,
  input  logic [NUM_WR-1:0][TAG_W-1:0]    wr_tag,
  input  logic [NUM_WR-1:0]               wr_valid
);
  localparam int ENT = SETS * WAYS;

  logic [ENT-1:0]    v_q, v_d, ent_we, blk;
  logic [TAG_W-1:0]  tag_q [ENT];
  logic [TAG_W-1:0]  tag_d [ENT];
  int                top_idx;

  always_comb begin
    v_d    = v_q;
    ent_we = '0;
    blk    = '0;
    for (int e = 0; e < ENT; e++) begin
      tag_d[e] = tag_q[e];
      for (int j = 0; j < NUM_WR; j++) begin
        if (wr_en[j] && (wr_set[j] == SET_W'(e / WAYS)) && (wr_way[j] == WAY_W'(e % WAYS))) begin
          blk[e]    = 1'b1;
          ent_we[e] = 1'b1;
          v_d[e]    = wr_valid[j];
          tag_d[e]  = wr_tag[j];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) v_q <= '0;
    else        v_q <= v_d;
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < ENT; e++) begin
      if (ent_we[e]) tag_q[e] <= tag_d[e];
    end
  end

  generate
    for (genvar r = 0; r < NUM_RD; r++) begin : g_rd
      always_comb begin
        rd_hit[r] = 1'b0;
        rd_way[r] = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
          if (v_q[int'(rd_set[r]) * WAYS + w] && !blk[int'(rd_set[r]) * WAYS + w] &&
              (tag_q[int'(rd_set[r]) * WAYS + w] == rd_tag[r])) begin
            rd_hit[r] = 1'b1;
            rd_way[r] = WAY_W'(w);
          end
        end
      end
    end
  endgenerate

  assign top_idx = int'(wr_set[NUM_WR-1]) * WAYS + int'(wr_way[NUM_WR-1]);

  AST_TAG_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en[NUM_WR-1] |=> (v_q[$past(top_idx)] == $past(wr_valid[NUM_WR-1]))); // R6
endmodule

// File: rtl/eta_lookup_array.sv
module eta_lookup_array
  import eta_pkg::*;
#(
  parameter int NUM_LK  = 2,
  parameter int NUM_UP  = 2,
  parameter int VA_W    = 32,
  parameter int PA_W    = 32,
  parameter int PAGE_W  = 12,
  parameter int LINE_W  = 4,
  parameter int SETS    = 16,
  parameter int WAYS    = 2,
  parameter int XLT_ENT = 4,
  parameter int ID_W    = 4,
  localparam int SET_W  = $clog2(SETS),
  localparam int WAY_W  = (WAYS > 1) ? $clog2(WAYS) : 1,
  localparam int SLOT_W = (XLT_ENT > 1) ? $clog2(XLT_ENT) : 1,
  localparam int VPN_W  = VA_W - PAGE_W,
  localparam int PPN_W  = PA_W - PAGE_W,
  localparam int TAG_W  = PA_W - LINE_W - SET_W
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [NUM_LK-1:0]               lk_valid,
  input  logic [NUM_LK-1:0][ID_W-1:0]     lk_id,
  input  logic [NUM_LK-1:0][VA_W-1:0]     lk_vaddr,
  input  logic [NUM_UP-1:0]               tu_en,
  input  logic [NUM_UP-1:0][SET_W-1:0]    tu_set,
  input  logic [NUM_UP-1:0][WAY_W-1:0]    tu_way,
  input  logic [NUM_UP-1:0][TAG_W-1:0]    tu_tag,
  input  logic [NUM_UP-1:0]               tu_valid,
  input  logic [NUM_UP-1:0]               xu_en,
  input  logic [NUM_UP-1:0][SLOT_W-1:0]   xu_slot,
  input  logic [NUM_UP-1:0][VPN_W-1:0]    xu_vpn,
  input  logic [NUM_UP-1:0][PPN_W-1:0]    xu_ppn,
  input  logic [NUM_UP-1:0]               xu_valid,
  output logic [NUM_LK-1:0]               rs_valid,
  output logic [NUM_LK-1:0][ID_W-1:0]     rs_id,
  output logic [NUM_LK-1:0]               rs_hit,
  output logic [NUM_LK-1:0][WAY_W-1:0]    rs_way,
  output logic [NUM_LK-1:0][PA_W-1:0]     rs_paddr,
  output logic [NUM_LK-1:0][1:0]          rs_miss
);
  // reset: asserted asynchronously, released on a clock edge
  logic rst_meta_n, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  logic [NUM_LK-1:0][VPN_W-1:0] lk_vpn;
  logic [NUM_LK-1:0][SET_W-1:0] lk_set;
  logic [NUM_LK-1:0]            xlt_hit, tag_hit;
  logic [NUM_LK-1:0][PPN_W-1:0] xlt_ppn;
  logic [NUM_LK-1:0][PA_W-1:0]  pa_c;
  logic [NUM_LK-1:0][TAG_W-1:0] ptag_c;
  logic [NUM_LK-1:0][WAY_W-1:0] tag_way;

  logic [NUM_LK-1:0]            hit_d;
  logic [NUM_LK-1:0][WAY_W-1:0] way_d;
  logic [NUM_LK-1:0][PA_W-1:0]  pa_d;
  miss_kind_e                   miss_d [NUM_LK];

  generate
    for (genvar i = 0; i < NUM_LK; i++) begin : g_split
      always_comb begin
        lk_vpn[i] = lk_vaddr[i][VA_W-1:PAGE_W];
        lk_set[i] = lk_vaddr[i][LINE_W +: SET_W];
        pa_c[i]   = {xlt_ppn[i], lk_vaddr[i][PAGE_W-1:0]};
        ptag_c[i] = pa_c[i][PA_W-1 -: TAG_W];
      end
    end
  endgenerate

  eta_xlt_shadow #(
    .NUM_RD(NUM_LK), .NUM_WR(NUM_UP), .ENTRIES(XLT_ENT),
    .SLOT_W(SLOT_W), .VPN_W(VPN_W), .PPN_W(PPN_W)
  ) u_xlt (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_vpn(lk_vpn), .rd_hit(xlt_hit), .rd_ppn(xlt_ppn),
    .wr_en(xu_en), .wr_slot(xu_slot), .wr_vpn(xu_vpn),
    .wr_ppn(xu_ppn), .wr_valid(xu_valid)
  );

  eta_tag_shadow #(
    .NUM_RD(NUM_LK), .NUM_WR(NUM_UP), .SETS(SETS), .WAYS(WAYS),
    .SET_W(SET_W), .WAY_W(WAY_W), .TAG_W(TAG_W)
  ) u_tag (
    .clk(clk), .rst_n(rst_sync_n),
    .rd_set(lk_set), .rd_tag(ptag_c), .rd_hit(tag_hit), .rd_way(tag_way),
    .wr_en(tu_en), .wr_set(tu_set), .wr_way(tu_way),
    .wr_tag(tu_tag), .wr_valid(tu_valid)
  );

  // result classification
  generate
    for (genvar i = 0; i < NUM_LK; i++) begin : g_cls
      always_comb begin
        hit_d[i]  = 1'b0;
        way_d[i]  = '0;
        pa_d[i]   = '0;
        miss_d[i] = MISS_XLT;
        if (xlt_hit[i]) begin
          pa_d[i] = pa_c[i];
          if (tag_hit[i]) begin
            hit_d[i]  = 1'b1;
            way_d[i]  = tag_way[i];
            miss_d[i] = MISS_NONE;
          end else begin
            miss_d[i] = MISS_TAG;
          end
        end
      end

      always_ff @(posedge clk or negedge rst_sync_n) begin
        if (!rst_sync_n) rs_valid[i] <= 1'b0;
        else             rs_valid[i] <= lk_valid[i];
      end

      always_ff @(posedge clk) begin
        if (lk_valid[i]) begin
          rs_id[i]    <= lk_id[i];
          rs_hit[i]   <= hit_d[i];
          rs_way[i]   <= way_d[i];
          rs_paddr[i] <= pa_d[i];
          rs_miss[i]  <= miss_d[i];
        end
      end

      AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_sync_n)
        lk_valid[i] |=> (rs_valid[i] && (rs_id[i] == $past(lk_id[i])))); // R2
      AST_IDLE_NO_RSP: assert property (@(posedge clk) disable iff (!rst_sync_n)
        !lk_valid[i] |=> !rs_valid[i]); // R2
      AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (rs_valid[i] && rs_hit[i]) |-> (rs_miss[i] == MISS_NONE)); // R3
      AST_XLT_MISS_NO_PA: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (rs_valid[i] && (rs_miss[i] == MISS_XLT)) |-> (!rs_hit[i] && (rs_paddr[i] == '0))); // R5

      for (genvar j = 0; j < NUM_UP; j++) begin : g_blk
        AST_TAG_CONFLICT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_sync_n)
          (lk_valid[i] && tu_en[j] && (tu_set[j] == lk_set[i]))
          |=> !(rs_hit[i] && (rs_way[i] == $past(tu_way[j])))); // R7
      end
    end
  endgenerate

  always @(posedge clk) begin
    AST_RESET_QUIET: assert (rst_sync_n || (rs_valid == '0)); // R1
  end
endmodule

// File: tb/eta_lookup_array_bench.sv
`timescale 1ns/1ps
module eta_lookup_array_bench;
  localparam int N = 2, M = 2, ID_W = 4, VA_W = 32, PA_W = 32;
  localparam int SETS = 16, WAYS = 2, XE = 4;
  localparam int SET_W = 4, WAY_W = 1, SLOT_W = 2, VPN_W = 20, PPN_W = 20, TAG_W = 24;

  logic clk = 1'b0;
  logic rst_n;
  always #10 clk = ~clk;

  logic [N-1:0]               lk_valid;
  logic [N-1:0][ID_W-1:0]     lk_id;
  logic [N-1:0][VA_W-1:0]     lk_vaddr;
  logic [M-1:0]               tu_en, tu_valid, xu_en, xu_valid;
  logic [M-1:0][SET_W-1:0]    tu_set;
  logic [M-1:0][WAY_W-1:0]    tu_way;
  logic [M-1:0][TAG_W-1:0]    tu_tag;
  logic [M-1:0][SLOT_W-1:0]   xu_slot;
  logic [M-1:0][VPN_W-1:0]    xu_vpn;
  logic [M-1:0][PPN_W-1:0]    xu_ppn;
  logic [N-1:0]               rs_valid, rs_hit;
  logic [N-1:0][ID_W-1:0]     rs_id;
  logic [N-1:0][WAY_W-1:0]    rs_way;
  logic [N-1:0][PA_W-1:0]     rs_paddr;
  logic [N-1:0][1:0]          rs_miss;

  eta_lookup_array u_eta_lookup_array (
    .clk, .rst_n, .lk_valid, .lk_id, .lk_vaddr,
    .tu_en, .tu_set, .tu_way, .tu_tag, .tu_valid,
    .xu_en, .xu_slot, .xu_vpn, .xu_ppn, .xu_valid,
    .rs_valid, .rs_id, .rs_hit, .rs_way, .rs_paddr, .rs_miss
  );

  // behavioural reference state
  bit               m_tv  [SETS][WAYS];
  logic [TAG_W-1:0] m_tg  [SETS][WAYS];
  bit               m_xv  [XE];
  logic [VPN_W-1:0] m_vpn [XE];
  logic [PPN_W-1:0] m_ppn [XE];

  bit               e_v    [N];
  logic [ID_W-1:0]  e_id   [N];
  bit               e_hit  [N];
  int               e_way  [N];
  logic [PA_W-1:0]  e_pa   [N];
  logic [1:0]       e_miss [N];

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  task automatic chk(input bit ok, input string lbl, input string fld, input int p,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s port%0d %s: actual %0h expected %0h", lbl, p, fld, act, exp);
    end
  endtask

  task automatic idle();
    lk_valid = '0; tu_en = '0; xu_en = '0;
    tu_valid = '1; xu_valid = '1;
  endtask

  task automatic predict();
    for (int i = 0; i < N; i++) begin
      bit th = 0; bit gh = 0; logic [PPN_W-1:0] ppn = '0; int w_hit = 0;
      logic [PA_W-1:0] pa; int s;
      e_v[i] = lk_valid[i];
      e_id[i] = lk_id[i];
      for (int k = 0; k < XE; k++) begin
        bit blk = 0;
        for (int j = 0; j < M; j++) if (xu_en[j] && int'(xu_slot[j]) == k) blk = 1;
        if (!th && m_xv[k] && !blk && m_vpn[k] == lk_vaddr[i][31:12]) begin
          th = 1; ppn = m_ppn[k];
        end
      end
      pa = {ppn, lk_vaddr[i][11:0]};
      s = int'(lk_vaddr[i][7:4]);
      if (th) begin
        for (int w = 0; w < WAYS; w++) begin
          bit blk = 0;
          for (int j = 0; j < M; j++)
            if (tu_en[j] && int'(tu_set[j]) == s && int'(tu_way[j]) == w) blk = 1;
          if (!gh && m_tv[s][w] && !blk && m_tg[s][w] == pa[31:8]) begin
            gh = 1; w_hit = w;
          end
        end
      end
      e_hit[i]  = th && gh;
      e_way[i]  = e_hit[i] ? w_hit : 0;
      e_pa[i]   = th ? pa : '0;
      e_miss[i] = !th ? 2'b10 : (gh ? 2'b00 : 2'b01);
    end
  endtask

  task automatic commit();
    for (int j = 0; j < M; j++) begin
      if (tu_en[j]) begin
        m_tv[int'(tu_set[j])][int'(tu_way[j])] = tu_valid[j];
        m_tg[int'(tu_set[j])][int'(tu_way[j])] = tu_tag[j];
      end
      if (xu_en[j]) begin
        m_xv[int'(xu_slot[j])]  = xu_valid[j];
        m_vpn[int'(xu_slot[j])] = xu_vpn[j];
        m_ppn[int'(xu_slot[j])] = xu_ppn[j];
      end
    end
  endtask

  // inputs are set after a falling edge; outputs sampled at the next falling edge
  task automatic tick(input string lbl);
    predict();
    @(posedge clk);
    commit();
    @(negedge clk);
    for (int i = 0; i < N; i++) begin
      chk(rs_valid[i] === e_v[i], lbl, "valid (R2)", i, 64'(rs_valid[i]), 64'(e_v[i]));
      if (e_v[i]) begin
        chk(rs_id[i] === e_id[i], lbl, "id (R2)", i, 64'(rs_id[i]), 64'(e_id[i]));
        chk(rs_hit[i] === e_hit[i], lbl, "hit", i, 64'(rs_hit[i]), 64'(e_hit[i]));
        chk(int'(rs_way[i]) == e_way[i], lbl, "way", i, 64'(rs_way[i]), 64'(e_way[i]));
        chk(rs_paddr[i] === e_pa[i], lbl, "paddr", i, 64'(rs_paddr[i]), 64'(e_pa[i]));
        chk(rs_miss[i] === e_miss[i], lbl, "miss", i, 64'(rs_miss[i]), 64'(e_miss[i]));
      end
    end
  endtask

  task automatic look(input int p, input logic [31:0] va);
    lk_valid[p] = 1'b1; lk_vaddr[p] = va; lk_id[p] = ID_W'($urandom);
  endtask
  task automatic tag_wr(input int p, input int s, input int w, input logic [23:0] t, input bit v);
    tu_en[p] = 1'b1; tu_set[p] = SET_W'(s); tu_way[p] = WAY_W'(w); tu_tag[p] = t; tu_valid[p] = v;
  endtask
  task automatic xlt_wr(input int p, input int k, input logic [19:0] vp, input logic [19:0] pp, input bit v);
    xu_en[p] = 1'b1; xu_slot[p] = SLOT_W'(k); xu_vpn[p] = vp; xu_ppn[p] = pp; xu_valid[p] = v;
  endtask

  function automatic logic [19:0] pmap(input int v);
    return 20'(v * 3 + 'h100);
  endfunction

  localparam logic [31:0] VA_A = 32'h1234_5534;   // set 3
  localparam logic [31:0] VA_B = 32'h0001_0120;   // set 2
  localparam logic [31:0] VA_C = 32'h1234_5550;   // set 5
  localparam logic [19:0] PA_A = 20'hABCDE, PA_B = 20'h00777;
  localparam logic [23:0] TG_A = 24'hABCDE5, TG_B = 24'h007771;

  initial begin
    lk_id = '0; lk_vaddr = '0; tu_set = '0; tu_way = '0; tu_tag = '0;
    xu_slot = '0; xu_vpn = '0; xu_ppn = '0;
    idle();
    rst_n = 1'b0;
    for (int s = 0; s < SETS; s++) for (int w = 0; w < WAYS; w++) begin m_tv[s][w] = 0; m_tg[s][w] = '0; end
    for (int k = 0; k < XE; k++) begin m_xv[k] = 0; m_vpn[k] = '0; m_ppn[k] = '0; end
    look(0, VA_A);                  // requests during reset must not answer
    repeat (3) begin
      @(negedge clk);
      chk(rs_valid === '0, "R1 reset", "valid", 0, 64'(rs_valid), 64'h0);
    end
    idle();
    rst_n = 1'b1;
    repeat (3) tick("R1 reset release idle");

    look(0, VA_A); look(1, VA_B); tick("R1 R5 empty after reset");
    idle();
    xlt_wr(0, 0, VA_A[31:12], PA_A, 1); xlt_wr(1, 1, VA_B[31:12], PA_B, 1);
    look(0, VA_A); tick("R8 install during lookup");
    idle(); look(0, VA_A); look(1, VA_B); tick("R4 R6 tag miss after install");
    idle(); tag_wr(0, 3, 1, TG_A, 1); tag_wr(1, 2, 0, TG_B, 1); tick("R6 tag install");
    idle(); look(0, VA_A); look(1, VA_B); tick("R3 R9 dual hit");
    idle(); tag_wr(0, 3, 1, TG_A, 1); tag_wr(1, 2, 1, 24'h0, 1);
    look(0, VA_A); look(1, VA_B); tick("R7 same way blocked, other way free");
    idle(); tag_wr(0, 9, 1, 24'h5, 1); look(0, VA_A); tick("R7 other set unaffected");
    idle(); xlt_wr(0, 0, VA_A[31:12], PA_A, 1); xlt_wr(1, 2, 20'h3, 20'h4, 1);
    look(0, VA_A); look(1, VA_B); tick("R8 slot blocked, other slot free");
    idle(); look(0, VA_A); tick("R8 R6 after rewrite");
    idle(); tag_wr(0, 3, 1, TG_A, 0); tick("R6 invalidate");
    idle(); look(0, VA_A); tick("R6 invalidated misses");
    idle(); tag_wr(0, 5, 0, 24'h111111, 1); tag_wr(1, 5, 0, TG_A, 1); tick("R9 dual write");
    idle(); look(0, VA_C); tick("R9 higher port kept");
    idle(); tag_wr(0, 5, 0, TG_A, 1); tag_wr(1, 5, 0, 24'h222222, 1); tick("R9 dual write rev");
    idle(); look(1, VA_C); tick("R9 higher port kept rev");
    idle(); xlt_wr(1, 1, VA_B[31:12], PA_B, 0); tick("R6 xlt invalidate");
    idle(); look(1, VA_B); tick("R5 R6 removed translation");

    for (int c = 0; c < 400; c++) begin
      idle();
      for (int i = 0; i < N; i++) if ($urandom_range(0, 2) != 0) begin
        int v = $urandom_range(0, 5);
        look(i, {20'(v), 4'($urandom_range(0, 1)), 4'($urandom_range(0, 3)), 4'($urandom)});
      end
      for (int j = 0; j < M; j++) begin
        if ($urandom_range(0, 2) == 0) begin
          int v = $urandom_range(0, 5); int h = $urandom_range(0, 1);
          tag_wr(j, $urandom_range(0, 3), $urandom_range(0, 1), {pmap(v), 4'(h)}, $urandom_range(0, 7) != 0);
        end
        if ($urandom_range(0, 3) == 0) begin
          int v = $urandom_range(0, 5);
          xlt_wr(j, $urandom_range(0, 3), 20'(v), pmap(v), $urandom_range(0, 7) != 0);
        end
      end
      tick("R3 R4 R5 R7 R8 R9 mixed traffic");
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog R2: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule